// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one integer by another over several clock cycles, one quotient bit per step. It handles both unsigned and two's-complement operands. A caller presents the dividend, the divisor and a signedness select, and pulses `start` while the block is idle. The block raises `busy` for a fixed number of cycles. As `busy` falls it pulses `done`, and at that moment the quotient and remainder appear. They stay on the outputs until the next division completes.

Internally the block works only on magnitudes. A divisor register twice the data width is loaded with the divisor magnitude in its upper half and shifts right once per step. A double-width remainder register starts out holding the dividend magnitude. On each step the block tries to subtract the divisor from the remainder. If the subtraction does not go negative it is kept and a 1 enters the quotient. If it goes negative the old remainder is kept and a 0 enters the quotient. After the last step a fix-up stage applies the signs. A zero divisor runs through the same sequence and yields a defined result plus a flag.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held and after its release, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are all zeros.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is then high for exactly DATA_W+2 cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again, and `busy` and `done` are never high together.
- R3: A `start` seen while `busy` is high is ignored. The running division keeps its operands and its timing.
- R4: With `signed_mode` = 0 and a nonzero divisor, `quotient` is the floor of dividend/divisor and `remainder` is dividend modulo divisor, both taken as unsigned.
- R5: With `signed_mode` = 1 and a nonzero divisor, the operands are read as two's complement. `quotient` is the true quotient truncated toward zero, so it is negative exactly when the operand signs differ and the true quotient is nonzero.
- R6: In signed mode a nonzero `remainder` has the sign of the dividend, and its magnitude is less than that of the divisor.
- R7: For every nonzero divisor, quotient × divisor + remainder equals the dividend, modulo 2^DATA_W.
- R8: In signed mode the most negative dividend divided by −1 gives a `quotient` equal to the most negative value (the bit pattern 1 followed by zeros) and a `remainder` of 0.
- R9: A zero divisor completes with the same latency as any other divisor. It gives a `quotient` of all ones, a `remainder` equal to the original dividend bits, and `div_by_zero` = 1, in both modes. `div_by_zero` is 0 for any nonzero divisor.
- R10: `quotient`, `remainder` and `div_by_zero` change only in a cycle where `done` is high. Between completions, including during a later division, they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a division; accepted only while idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | DATA_W | Dividend, sampled on acceptance |
| divisor | input | DATA_W | Divisor, sampled on acceptance |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Last completed division had a zero divisor |
| quotient | output | DATA_W | Quotient of the last completed division |
| remainder | output | DATA_W | Remainder of the last completed division |

## Verification
The bench sweeps every operand pair of a 5-bit instance in both modes. It compares results against integer division done in the bench, and it checks the reconstruction identity and the latency of each run.

The sweep covers these cases:
- The most negative dividend over −1. A wrong magnitude width or fix-up would lose the wrapped quotient or give a nonzero remainder.
- Negative dividends with exact and inexact quotients. A fix-up keyed to the divisor sign would give remainders of the wrong sign.
- Zero divisors. A design that returned the sign-fixed internal result would report a negated quotient or a magnitude remainder, and one that skipped the loop would finish early.
- A second `start` during a run, and outputs during a later run. A design that relatched operands would give the second operand pair's result or a shifted `done`, and one that exposed its working registers would show outputs changing mid-run.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep #(
  parameter int DATA_W = 32
) (
  input  logic              signed_mode,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] mag_dvd,
  output logic [DATA_W-1:0] mag_dvs,
  output logic              neg_quot,
  output logic              neg_rem
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  // Magnitude of a value; only negated when signed and the sign bit is set.
  function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] v,
                                                   input logic sg);
    return (sg && v[MSB]) ? (~v + ONE) : v;
  endfunction

  assign mag_dvd  = magnitude(dividend, signed_mode);
  assign mag_dvs  = magnitude(divisor, signed_mode);
  // Quotient sign follows disagreement of operand signs.
  assign neg_quot = signed_mode & (dividend[MSB] ^ divisor[MSB]);
  // Remainder sign follows the dividend.
  assign neg_rem  = signed_mode & dividend[MSB];
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_fire,
  output logic step_fire,
  output logic fin_fire,
  output logic busy
);
  import div_pkg::*;

  localparam int STEPS = DATA_W + 1;
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_STEP;
            cnt_q   <= '0;
          end
        end
        ST_STEP: begin
          if (cnt_q == LAST) state_q <= ST_FIX;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_fire = (state_q == ST_IDLE) && start;
  assign step_fire = (state_q == ST_STEP);
  assign fin_fire  = (state_q == ST_FIX);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_fire,
  input  logic              step_fire,
  input  logic [DATA_W-1:0] mag_dvd,
  input  logic [DATA_W-1:0] mag_dvs,
  output logic              step_bit,
  output logic [DATA_W-1:0] quo_raw,
  output logic [DATA_W-1:0] rem_raw
);
  localparam int DW2 = 2 * DATA_W;

  logic [DW2-1:0]    rem_q;
  logic [DW2-1:0]    dvs_q;
  logic [DATA_W-1:0] quo_q;
  logic [DW2:0]      trial;

  // Trial subtraction one bit wider than the registers; the top bit is the borrow.
  function automatic logic [DW2:0] try_sub(input logic [DW2-1:0] r,
                                           input logic [DW2-1:0] d);
    return {1'b0, r} - {1'b0, d};
  endfunction

  assign trial    = try_sub(rem_q, dvs_q);
  assign step_bit = ~trial[DW2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
    end else if (load_fire) begin
      rem_q <= {{DATA_W{1'b0}}, mag_dvd};
      dvs_q <= {mag_dvs, {DATA_W{1'b0}}};
      quo_q <= '0;
    end else if (step_fire) begin
      if (step_bit) rem_q <= trial[DW2-1:0];
      quo_q <= {quo_q[DATA_W-2:0], step_bit};
      dvs_q <= dvs_q >> 1;
    end
  end

  assign quo_raw = quo_q;
  assign rem_raw = rem_q[DATA_W-1:0];
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              signed_mode,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic              div_by_zero,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              load_fire, step_fire, fin_fire, step_bit;
  logic [DATA_W-1:0] mag_dvd, mag_dvs, quo_raw, rem_raw;
  logic              neg_quot, neg_rem;
  logic              neg_quot_q, neg_rem_q, dbz_q;
  logic [DATA_W-1:0] dvd_q;
  logic              done_q, dbz_out_q;
  logic [DATA_W-1:0] quot_q, rem_q;

  function automatic logic [DATA_W-1:0] cond_negate(input logic [DATA_W-1:0] v,
                                                     input logic neg);
    return neg ? (~v + ONE) : v;
  endfunction

  div_sign_prep #(.DATA_W(DATA_W)) prep_i (
    .signed_mode(signed_mode),
    .dividend   (dividend),
    .divisor    (divisor),
    .mag_dvd    (mag_dvd),
    .mag_dvs    (mag_dvs),
    .neg_quot   (neg_quot),
    .neg_rem    (neg_rem)
  );

  div_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_fire(load_fire),
    .step_fire(step_fire),
    .fin_fire (fin_fire),
    .busy     (busy)
  );

  div_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_fire(load_fire),
    .step_fire(step_fire),
    .mag_dvd  (mag_dvd),
    .mag_dvs  (mag_dvs),
    .step_bit (step_bit),
    .quo_raw  (quo_raw),
    .rem_raw  (rem_raw)
  );

  // Sign decisions and the original dividend are captured at acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg_quot_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      dbz_q      <= 1'b0;
      dvd_q      <= '0;
    end else if (load_fire) begin
      neg_quot_q <= neg_quot;
      neg_rem_q  <= neg_rem;
      dbz_q      <= (divisor == '0);
      dvd_q      <= dividend;
    end
  end

  // Fix-up stage: result registers written once per division.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      dbz_out_q <= 1'b0;
      quot_q    <= '0;
      rem_q     <= '0;
    end else begin
      done_q <= fin_fire;
      if (fin_fire) begin
        dbz_out_q <= dbz_q;
        if (dbz_q) begin
          quot_q <= '1;
          rem_q  <= dvd_q;
        end else begin
          quot_q <= cond_negate(quo_raw, neg_quot_q);
          rem_q  <= cond_negate(rem_raw, neg_rem_q);
        end
      end
    end
  end

  assign done        = done_q;
  assign div_by_zero = dbz_out_q;
  assign quotient    = quot_q;
  assign remainder   = rem_q;
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              signed_mode,
  input logic [DATA_W-1:0] dividend,
  input logic [DATA_W-1:0] divisor,
  input logic              busy,
  input logic              done,
  input logic              div_by_zero,
  input logic [DATA_W-1:0] quotient,
  input logic [DATA_W-1:0] remainder,
  input logic              step_fire
);
  localparam int LAT   = DATA_W + 2;
  localparam int LAT_W = $clog2(LAT + 2) + 1;

  logic [DATA_W-1:0] lat_dvd, lat_dvs;
  logic              lat_sg;
  logic [LAT_W-1:0]  lat_cnt;
  logic [DATA_W-1:0] recon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_dvd <= '0;
      lat_dvs <= '0;
      lat_sg  <= 1'b0;
      lat_cnt <= '0;
    end else if (start && !busy) begin
      lat_dvd <= dividend;
      lat_dvs <= divisor;
      lat_sg  <= signed_mode;
      lat_cnt <= '0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assign recon = quotient * lat_dvs + remainder;

  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_done_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: a restart mid-run would reset the latency count seen here
  a_r3_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LAT_W'(LAT)));
  a_r2_steps_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> busy);
  a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (recon == lat_dvd));
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !lat_sg && lat_dvs != '0) |-> (remainder < lat_dvs));
  a_r6_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lat_sg && lat_dvs != '0 && remainder != '0)
      |-> (remainder[DATA_W-1] == lat_dvd[DATA_W-1]));
  a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_by_zero == (lat_dvs == '0)));
  a_r9_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> ((&quotient) && remainder == lat_dvd));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

bind restoring_divider restoring_divider_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .signed_mode(signed_mode),
  .dividend   (dividend),
  .divisor    (divisor),
  .busy       (busy),
  .done       (done),
  .div_by_zero(div_by_zero),
  .quotient   (quotient),
  .remainder  (remainder),
  .step_fire  (step_fire)
);

// File: tb/restoring_divider_tb_top.sv
module restoring_divider_tb_top;
  localparam int W = 5;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = W + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         signed_mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  restoring_divider #(.DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .div_by_zero(div_by_zero), .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int to_int(input logic [W-1:0] v, input bit sg);
    return (sg && v[W-1]) ? int'(v) - (1 << W) : int'(v);
  endfunction

  // Expected result from plain integer arithmetic.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sg,
                       output logic [W-1:0] eq, output logic [W-1:0] er,
                       output bit edbz);
    int ia, ib, iq, ir;
    if (b == '0) begin
      eq = '1; er = a; edbz = 1'b1;
    end else begin
      ia = to_int(a, sg); ib = to_int(b, sg);
      iq = ia / ib; ir = ia % ib;
      eq = iq[W-1:0]; er = ir[W-1:0]; edbz = 1'b0;
    end
  endtask

  // Issue one division; returns result and busy-cycle count seen at negedges.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit sg,
                         output logic [W-1:0] q, output logic [W-1:0] r,
                         output bit dbz, output int lat);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; signed_mode = sg;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 4 * LAT) begin
      if (busy) lat++;
      @(negedge clk);
    end
    q = quotient; r = remainder; dbz = div_by_zero;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] q, r, eq, er, q0, r0;
    bit dbz, edbz;
    int lat;
    string tag;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && div_by_zero == 0, "R1", "flags in reset",
          int'({busy, done, div_by_zero}), 0);
    check(quotient == '0 && remainder == '0, "R1", "results in reset",
          int'({quotient, remainder}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && quotient == '0, "R1", "after release",
          int'({busy, done}), 0);

    // Exhaustive sweep: R2 R4 R5 R6 R7 R8 R9
    for (int sg = 0; sg < 2; sg++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          run_div(W'(a), W'(b), bit'(sg), q, r, dbz, lat);
          model(W'(a), W'(b), bit'(sg), eq, er, edbz);
          if (b == 0) tag = "R9";
          else if (sg == 1 && a == (1 << (W-1)) && b == (1 << W) - 1) tag = "R8";
          else if (sg == 1) tag = "R5 R6";
          else tag = "R4";
          check(q == eq, tag, $sformatf("quotient %0d/%0d sg=%0d", a, b, sg),
                int'(q), int'(eq));
          check(r == er, tag, $sformatf("remainder %0d/%0d sg=%0d", a, b, sg),
                int'(r), int'(er));
          check(dbz == edbz, "R9", $sformatf("dbz flag %0d/%0d", a, b),
                int'(dbz), int'(edbz));
          check(lat == LAT && !busy, "R2", $sformatf("latency %0d/%0d", a, b),
                lat, LAT);
          if (b != 0) begin
            logic [W-1:0] rc;
            rc = q * W'(b) + r;
            check(rc == W'(a), "R7", $sformatf("identity %0d/%0d sg=%0d", a, b, sg),
                  int'(rc), a);
          end
        end
      end
    end

    // R2: done lasts one cycle
    @(negedge clk);
    check(done == 0, "R2", "done single cycle", int'(done), 0);

    // R3: start during busy ignored (22/3 unsigned, then 7/2 attempted)
    @(negedge clk);
    start = 1'b1; dividend = 5'd22; divisor = 5'd3; signed_mode = 1'b0;
    @(negedge clk);
    dividend = 5'd7; divisor = 5'd2;
    lat = 1;
    repeat (2) begin
      @(negedge clk);
      if (busy) lat++;
    end
    start = 1'b0;
    while (!done && lat < 4 * LAT) begin
      @(negedge clk);
      if (busy) lat++;
    end
    check(lat == LAT, "R3", "latency with restart attempt", lat, LAT);
    check(quotient == 5'd7 && remainder == 5'd1, "R3", "kept first operands",
          int'({quotient, remainder}), int'({5'd7, 5'd1}));

    // R10: outputs hold after done and during a later run
    q0 = quotient; r0 = remainder;
    repeat (4) @(negedge clk);
    check(quotient == q0 && remainder == r0, "R10", "hold while idle",
          int'({quotient, remainder}), int'({q0, r0}));
    start = 1'b1; dividend = 5'd9; divisor = 5'd0; signed_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy && quotient == q0 && remainder == r0 && !div_by_zero, "R10",
          "hold during run", int'({quotient, remainder}), int'({q0, r0}));
    while (!done) @(negedge clk);
    check(div_by_zero && quotient == '1 && remainder == 5'd9, "R9",
          "signed zero divisor", int'({quotient, remainder}), int'({5'h1f, 5'd9}));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule